// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver with Word Queue

This block turns an asynchronous serial line into parallel words. It runs on the system clock and advances its bit timing only on a single-cycle enable, `tick16`, that pulses sixteen times per bit period. The enable comes from a baud divider outside the block. The line input is first passed through a two-flop synchronizer. A frame begins when the synchronized line is seen to fall between two consecutive ticks. Every bit of the frame is then decided by a two-of-three vote taken over the 7th, 8th and 9th ticks of that bit. The start bit is decided the same way as the data bits.

Each frame holds a start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one stop bit. A completed word is written into an 8-entry first-in first-out queue together with its received parity bit and a framing-error flag. The oldest entry is always visible at the outputs. A one-cycle pop strobe discards the oldest entry. If a word completes while the queue is full and no pop happens in the same cycle, the whole queue is emptied and the new word is discarded as well.

Top module: `mv_uart_rx`

## Requirements
- R1: After reset, and whenever the queue is empty, `rdReady`, `rdData`, `rdParity` and `rdFrameErr` all read 0.
- R2: With `wordLen8`=1, the eight bits that follow the start bit are assembled least significant bit first, so the first data bit lands in `rdData[0]`.
- R3: With `wordLen8`=0, a frame carries seven data bits, the stop bit (or the parity bit) follows the seventh, and `rdData[7]` reads 0.
- R4: With `parityEn`=1, the bit that follows the last data bit is stored unchanged as `rdParity`, and the block does not check it against the data. With `parityEn`=0 no parity bit is expected and `rdParity` reads 0.
- R5: A stop bit that votes low sets `rdFrameErr` to 1 for that word. A stop bit that votes high stores 0.
- R6: Each bit value is the majority of the line values at the 7th, 8th and 9th ticks of that bit, where the tick that detected the falling edge counts as tick 1 of the start bit. A single opposing value among those three ticks, and any value at the other ticks, leave the bit unchanged. Two opposing values invert it.
- R7: A start bit that votes high is treated as a glitch. The receiver goes back to idle without storing a word and accepts the next falling edge as a new start.
- R8: Words leave the queue in the order they arrived, up to 8 words. A word completing into an empty queue raises `rdReady`.
- R9: A word that completes while the queue holds 8 entries and `popReq` is low empties the queue and is itself discarded. The word after that is stored normally.
- R10: A `popReq` pulse removes exactly the oldest entry. A pop while the queue is empty has no effect. Without a pop or a new word, the outputs hold their values.
- R11: `wordLen8` and `parityEn` are captured at the start edge and hold for the whole frame. Changing them during a frame does not change how that frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable, 16 pulses per bit period |
| rxIn | input | 1 | Asynchronous serial line, idles high |
| wordLen8 | input | 1 | 1 selects 8 data bits, 0 selects 7 |
| parityEn | input | 1 | 1 expects a parity bit after the data |
| popReq | input | 1 | One-cycle strobe that removes the oldest word |
| rdData | output | 8 | Data of the oldest stored word |
| rdParity | output | 1 | Received parity bit of the oldest word |
| rdFrameErr | output | 1 | Stop bit of the oldest word was sampled low |
| rdReady | output | 1 | Queue holds at least one word |

## Verification
The hardest conditions to reach from the ports are those that depend on the position of a line change inside the vote window. These include a single deviant sample that the vote must reject, a pair of deviant samples that must flip a bit, and a short low pulse that must be dropped as a false start. The bench therefore drives the line one tick at a time. It lets each value settle through the synchronizer before the tick that samples it, so that tick k of every bit is known exactly, and then it inverts chosen ticks inside chosen bits. Overflow is reached by filling the queue with eight frames and sending a ninth without popping. The bench then checks that the queue is empty and that the next word is stored normally.

// File: rtl/mv_rx_pkg.sv
package mv_rx_pkg;

  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    BIT_START = 2'd0,
    BIT_DATA  = 2'd1,
    BIT_PAR   = 2'd2,
    BIT_STOP  = 2'd3
  } bitKind_e;

  // Strobes from the timing control to the datapath
  typedef struct packed {
    logic             frameStart;
    logic             capA;
    logic             capB;
    logic             decide;
    bitKind_e         kind;
    logic [IDX_W-1:0] dataIdx;
  } rxStrobe_t;

endpackage

// File: rtl/mv_rx_fifo.sv
module mv_rx_fifo #(
  parameter int WIDTH = 10,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushWord,
  input  logic             pop,
  output logic [WIDTH-1:0] headWord,
  output logic             notEmpty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic full, flush, doPush, doPop;

  always_comb begin
    full     = (count == CNT_FULL);
    notEmpty = (count != '0);
    flush    = push && full && !pop;
    doPop    = pop && notEmpty;
    doPush   = push && !flush;
    headWord = mem[rdPtr];
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + PTR_W'(1);
      if (doPop)  rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end
endmodule

// File: rtl/mv_rx_ctrl.sv
module mv_rx_ctrl
  import mv_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      rxSync,
  input  logic      vote,
  input  logic      wordLen8,
  input  logic      parityEn,
  output rxStrobe_t strb,
  output logic      rxBusy
);
  localparam int CNT_W = $clog2(OVS + 1);
  localparam int BIT_W = $clog2(DATA_W + 4);
  localparam logic [CNT_W-1:0] SAMP_A   = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] SAMP_B   = CNT_W'(OVS / 2);
  localparam logic [CNT_W-1:0] SAMP_C   = CNT_W'(OVS / 2 + 1);
  localparam logic [CNT_W-1:0] SAMP_END = CNT_W'(OVS);
  localparam logic [CNT_W-1:0] SAMP_ONE = CNT_W'(1);
  localparam logic [BIT_W-1:0] LEN_LONG  = BIT_W'(DATA_W);
  localparam logic [BIT_W-1:0] LEN_SHORT = BIT_W'(DATA_W - 1);

  logic [CNT_W-1:0] sampCnt, nextSamp;
  logic [BIT_W-1:0] bitIdx, dataLen;
  logic busyQ, len8Q, parQ, rxPrev, startSeen, tickBusy, frameDone;
  bitKind_e kind;

  always_comb begin
    dataLen   = len8Q ? LEN_LONG : LEN_SHORT;
    nextSamp  = (sampCnt == SAMP_END) ? SAMP_ONE : sampCnt + SAMP_ONE;
    startSeen = !busyQ && tick16 && rxPrev && !rxSync;
    tickBusy  = busyQ && tick16;
    if (bitIdx == '0)                                 kind = BIT_START;
    else if (bitIdx <= dataLen)                       kind = BIT_DATA;
    else if (parQ && (bitIdx == dataLen + BIT_W'(1))) kind = BIT_PAR;
    else                                              kind = BIT_STOP;
    strb.frameStart = startSeen;
    strb.capA       = tickBusy && (nextSamp == SAMP_A);
    strb.capB       = tickBusy && (nextSamp == SAMP_B);
    strb.decide     = tickBusy && (nextSamp == SAMP_C);
    strb.kind       = kind;
    strb.dataIdx    = IDX_W'(bitIdx - BIT_W'(1));
    frameDone       = strb.decide && ((kind == BIT_START && vote) || kind == BIT_STOP);
    rxBusy          = busyQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      sampCnt <= '0;
      bitIdx  <= '0;
      len8Q   <= 1'b1;
      parQ    <= 1'b0;
      rxPrev  <= 1'b1;
    end else begin
      if (tick16) rxPrev <= rxSync;
      if (startSeen) begin
        busyQ   <= 1'b1;
        sampCnt <= SAMP_ONE;
        bitIdx  <= '0;
        len8Q   <= wordLen8;
        parQ    <= parityEn;
      end else if (tickBusy) begin
        sampCnt <= nextSamp;
        if (sampCnt == SAMP_END) bitIdx <= bitIdx + BIT_W'(1);
        if (frameDone) busyQ <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mv_rx_datapath.sv
module mv_rx_datapath
  import mv_rx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxSync,
  input  rxStrobe_t         strb,
  input  logic              popReq,
  output logic              vote,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParity,
  output logic              rdFrameErr,
  output logic              rdReady
);
  localparam int WORD_W = DATA_W + 2;

  logic sA, sB, parBit, push, notEmpty;
  logic [DATA_W-1:0] shiftReg;
  logic [WORD_W-1:0] pushWord, headWord;

  always_comb begin
    vote     = (sA & sB) | (sA & rxSync) | (sB & rxSync);
    push     = strb.decide && (strb.kind == BIT_STOP);
    pushWord = {!vote, parBit, shiftReg};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sA       <= 1'b1;
      sB       <= 1'b1;
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strb.frameStart) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
      end
      if (strb.capA) sA <= rxSync;
      if (strb.capB) sB <= rxSync;
      if (strb.decide && strb.kind == BIT_DATA) shiftReg[strb.dataIdx] <= vote;
      if (strb.decide && strb.kind == BIT_PAR)  parBit <= vote;
    end
  end

  mv_rx_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .push     (push),
    .pushWord (pushWord),
    .pop      (popReq),
    .headWord (headWord),
    .notEmpty (notEmpty)
  );

  always_comb begin
    rdReady    = notEmpty;
    rdData     = notEmpty ? headWord[DATA_W-1:0] : '0;
    rdParity   = notEmpty & headWord[DATA_W];
    rdFrameErr = notEmpty & headWord[DATA_W+1];
  end
endmodule

// File: rtl/mv_uart_rx.sv
module mv_uart_rx
  import mv_rx_pkg::*;
#(
  parameter int OVS   = 16,
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick16,
  input  logic              rxIn,
  input  logic              wordLen8,
  input  logic              parityEn,
  input  logic              popReq,
  output logic [DATA_W-1:0] rdData,
  output logic              rdParity,
  output logic              rdFrameErr,
  output logic              rdReady
);
  logic rxMeta, rxSync, vote, rxBusy;
  rxStrobe_t strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxSync <= rxMeta;
    end
  end

  mv_rx_ctrl #(.OVS(OVS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tick16   (tick16),
    .rxSync   (rxSync),
    .vote     (vote),
    .wordLen8 (wordLen8),
    .parityEn (parityEn),
    .strb     (strb),
    .rxBusy   (rxBusy)
  );

  mv_rx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxSync     (rxSync),
    .strb       (strb),
    .popReq     (popReq),
    .vote       (vote),
    .rdData     (rdData),
    .rdParity   (rdParity),
    .rdFrameErr (rdFrameErr),
    .rdReady    (rdReady)
  );
endmodule

// File: rtl/mv_rx_checker.sv
module mv_rx_checker
  import mv_rx_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              popReq,
  input logic              rdReady,
  input logic [DATA_W-1:0] rdData,
  input rxStrobe_t         strb,
  input logic              vote,
  input logic              rxBusy
);
  logic pushNow;
  assign pushNow = strb.decide && (strb.kind == BIT_STOP);

  p_push_raises_ready_r8: assert property (@(posedge clk) disable iff (!rstN)
    pushNow && !rdReady |=> rdReady);

  p_head_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    !popReq && !pushNow |=> $stable(rdData) && $stable(rdReady));

  p_empty_pop_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdReady && popReq && !pushNow |=> !rdReady);

  p_false_start_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.decide && strb.kind == BIT_START && vote |=> !rxBusy);

  p_vote_points_apart_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capA, strb.capB, strb.decide}));
endmodule

bind mv_uart_rx mv_rx_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .popReq  (popReq),
  .rdReady (rdReady),
  .rdData  (rdData),
  .strb    (strb),
  .vote    (vote),
  .rxBusy  (rxBusy)
);

// File: tb/mv_uart_rx_tb.sv
`timescale 1ns/1ps
module mv_uart_rx_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick16 = 1'b0;
  logic rxIn = 1'b1;
  logic wordLen8 = 1'b1;
  logic parityEn = 1'b0;
  logic popReq = 1'b0;
  logic [7:0] rdData;
  logic rdParity, rdFrameErr, rdReady;

  int nChk = 0;
  int nBad = 0;
  logic [7:0] expQ [8];

  always #2.5 clk = ~clk;

  mv_uart_rx u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxIn(rxIn),
    .wordLen8(wordLen8), .parityEn(parityEn), .popReq(popReq),
    .rdData(rdData), .rdParity(rdParity), .rdFrameErr(rdFrameErr),
    .rdReady(rdReady)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One 16x sample period: the line settles, then one tick samples it
  task automatic step(input logic v);
    @(negedge clk); rxIn = v; tick16 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk); tick16 = 1'b1;
    @(negedge clk); tick16 = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit len8, input bit parEn,
                           input bit parBit, input bit stopBit,
                           input int flipBit, input logic [15:0] flipMask,
                           input bit swapCfg);
    logic bits [12];
    int nb;
    nb = 0;
    bits[nb++] = 1'b0;
    for (int i = 0; i < (len8 ? 8 : 7); i++) bits[nb++] = d[i];
    if (parEn) bits[nb++] = parBit;
    bits[nb++] = stopBit;
    wordLen8 = len8;
    parityEn = parEn;
    for (int b = 0; b < nb; b++) begin
      for (int s = 1; s <= 16; s++)
        step(bits[b] ^ ((b == flipBit) && flipMask[s-1]));
      if (b == 0 && swapCfg) begin
        wordLen8 = !len8;
        parityEn = !parEn;
      end
    end
    wordLen8 = len8;
    parityEn = parEn;
    step(1'b1);
    step(1'b1);
  endtask

  task automatic plain(input logic [7:0] d, input bit len8);
    sendFrame(d, len8, 1'b0, 1'b0, 1'b1, -1, 16'h0, 1'b0);
  endtask

  task automatic popWord();
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkHead(input string req, input logic [7:0] d,
                           input logic p, input logic fe);
    chk({req, " ready"}, rdReady, 1);
    chk({req, " data"}, rdData, d);
    chk({req, " parity"}, rdParity, p);
    chk({req, " frameErr"}, rdFrameErr, fe);
  endtask

  task automatic checkEmpty(input string req);
    chk({req, " ready"}, rdReady, 0);
    chk({req, " data"}, rdData, 0);
    chk({req, " parity"}, rdParity, 0);
    chk({req, " frameErr"}, rdFrameErr, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) step(1'b1);

    // R1: reset state
    checkEmpty("R1 reset");

    // R2 / R8 / R10: two batches of eight 8-bit words, popped in order
    for (int g = 0; g < 2; g++) begin
      for (int i = 0; i < 8; i++) begin
        expQ[i] = 8'((g * 8 + i) * 29 + 5);
        plain(expQ[i], 1'b1);
        if (i == 0) chk("R8 push into empty raises ready", rdReady, 1);
      end
      for (int i = 0; i < 8; i++) begin
        checkHead("R2 R8 in-order word", expQ[i], 1'b0, 1'b0);
        chk("R4 parity reads 0 when disabled", rdParity, 0);
        popWord();
      end
      checkEmpty("R10 empty after popping all");
    end

    // R3 / R4: 7-bit words with parity, parity deliberately unrelated to data
    for (int i = 0; i < 8; i++) begin
      logic [7:0] d;
      logic p;
      d = 8'(i * 37 + 3) | 8'h80;
      p = i[0];
      sendFrame(d, 1'b0, 1'b1, p, 1'b1, -1, 16'h0, 1'b0);
      checkHead("R3 R4 seven-bit word with parity", d & 8'h7F, p, 1'b0);
      chk("R3 top bit reads 0", rdData[7], 0);
      popWord();
    end
    // R4: 8-bit with parity set
    sendFrame(8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, -1, 16'h0, 1'b0);
    checkHead("R4 eight-bit word with parity", 8'hC3, 1'b1, 1'b0);
    popWord();

    // R5: low stop bit, then a clean word
    sendFrame(8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, -1, 16'h0, 1'b0);
    checkHead("R5 frame error flagged", 8'hA5, 1'b0, 1'b1);
    popWord();
    plain(8'h5A, 1'b1);
    checkHead("R5 clean word after error", 8'h5A, 1'b0, 1'b0);
    popWord();

    // R6: vote window on data bit 3 (frame bit index 4)
    sendFrame(8'h0F, 1'b1, 1'b0, 1'b0, 1'b1, 4, 16'h0080, 1'b0);
    checkHead("R6 single deviant sample 8 rejected", 8'h0F, 1'b0, 1'b0);
    popWord();
    sendFrame(8'h0F, 1'b1, 1'b0, 1'b0, 1'b1, 4, 16'hFE3F, 1'b0);
    checkHead("R6 samples outside 7..9 ignored", 8'h0F, 1'b0, 1'b0);
    popWord();
    sendFrame(8'h0F, 1'b1, 1'b0, 1'b0, 1'b1, 4, 16'h00C0, 1'b0);
    checkHead("R6 two deviant samples flip bit", 8'h07, 1'b0, 1'b0);
    popWord();
    sendFrame(8'h33, 1'b1, 1'b0, 1'b0, 1'b1, 0, 16'h0100, 1'b0);
    checkHead("R6 start bit tolerates one sample", 8'h33, 1'b0, 1'b0);
    popWord();

    // R7: short low pulse on the line is a false start
    for (int s = 0; s < 6; s++) step(1'b0);
    for (int s = 0; s < 40; s++) step(1'b1);
    checkEmpty("R7 false start stores nothing");
    plain(8'h96, 1'b1);
    checkHead("R7 next frame after false start", 8'h96, 1'b0, 1'b0);
    popWord();

    // R9: overflow flushes the whole queue
    for (int i = 0; i < 8; i++) plain(8'(i + 8'h40), 1'b1);
    checkHead("R9 full queue head", 8'h40, 1'b0, 1'b0);
    plain(8'hEE, 1'b1);
    checkEmpty("R9 overflow empties queue");
    plain(8'h11, 1'b1);
    checkHead("R9 word after flush", 8'h11, 1'b0, 1'b0);
    popWord();
    checkEmpty("R9 flushed words gone");

    // R10: pop on empty has no effect
    popWord();
    checkEmpty("R10 pop on empty");
    plain(8'h77, 1'b1);
    plain(8'h88, 1'b1);
    checkHead("R10 oldest first", 8'h77, 1'b0, 1'b0);
    popWord();
    checkHead("R10 one pop removes one", 8'h88, 1'b0, 1'b0);
    popWord();

    // R11: configuration changed mid-frame is ignored
    sendFrame(8'hB9, 1'b1, 1'b0, 1'b0, 1'b1, -1, 16'h0, 1'b1);
    checkHead("R11 config held for the frame", 8'hB9, 1'b0, 1'b0);
    popWord();
    sendFrame(8'h2C, 1'b0, 1'b1, 1'b1, 1'b1, -1, 16'h0, 1'b1);
    checkHead("R11 short config held", 8'h2C, 1'b1, 1'b0);
    popWord();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule